// File: doc/BRIEF.md
# Half-Warp Memory Request Coalescer

This block takes one memory request from a group of sixteen lanes: each lane has a byte address, an active-mask bit marks which lanes take part, and a shared element-size code gives the access width. It turns that request into a short series of aligned memory transactions. Each transaction covers every still-pending lane whose address falls in one segment. Each transaction goes out on a valid/ready channel carrying an aligned base address, a size code and the mask of lanes it serves.

Each transaction starts from the lowest-numbered lane still pending. The segment size comes from the element width. When every merged address lies in one aligned half of the segment, the segment is halved, and it can be halved twice. Lanes that have been served drop out of the pending set. A one-cycle done pulse marks the end of the request. The block takes a new request only when it is idle. Lane addresses are assumed to be aligned to the element size, so no element crosses a 32-byte boundary.

Top module: `coal_unit`

## Requirements
- R1: After reset, req_ready is 1 and txn_valid and done are 0. req_ready is 1 only while the block is idle, and a request is taken on a clock edge where req_valid and req_ready are both 1.
- R2: req_esize selects the starting segment: 0 (1-byte) gives 32 bytes, 1 (2-byte) gives 64 bytes, and 2 (4-byte) or 3 (8-byte) give 128 bytes. txn_size encodes 0 = 32, 1 = 64 and 2 = 128 bytes.
- R3: Each transaction is built around the lowest-numbered pending lane. Its txn_mask holds that lane and every other pending lane whose address lies in the same starting segment. Lane i is bit i of txn_mask and of req_mask, and its address is bits [32*i+31:32*i] of req_addr.
- R4: A 128-byte transaction becomes 64 bytes when all served addresses agree in address bit 6. A 64-byte transaction, whether it started at 64 or was just halved, becomes 32 bytes when all served addresses also agree in bit 5.
- R5: txn_addr is the lowest pending lane's address with its low bits cleared to the final transaction size.
- R6: Lanes that have been served leave the pending set, so each active lane is served exactly once. Addresses of lanes with a 0 mask bit have no effect on any transaction.
- R7: done is a one-cycle pulse in the cycle after the last transaction is accepted. An all-zero req_mask produces no transaction and raises done in the cycle after the request is taken.
- R8: While txn_valid is 1 and txn_ready is 0, the transaction fields stay stable and txn_valid stays 1.
- R9: done and txn_valid are never 1 together, and txn_valid is never 1 while req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 512 | Sixteen 32-bit lane byte addresses, lane 0 in the low bits |
| req_mask | input | 16 | Active lanes |
| req_esize | input | 2 | Element width code |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Transaction taken by the memory side |
| txn_addr | output | 32 | Aligned transaction base address |
| txn_size | output | 2 | Transaction size code |
| txn_mask | output | 16 | Lanes served by this transaction |
| done | output | 1 | Request complete pulse |

## Verification
The directed patterns each isolate one decision:
- Unit-stride words split apart the 128-to-64 reduction from a full 128-byte burst.
- Stride-8 words keep the full 128-byte burst.
- Byte accesses fit a single 32-byte segment.
- Spread halfwords force several 64-byte transactions.
- A broadcast address with a sparse mask tests merging with gaps in the mask.
- A reversed layout shows that the leader is picked by lane number, not by address.
- Garbage addresses on masked-off lanes show that those lanes are ignored.
- An empty mask exercises the done-only path.

Randomised requests use both narrow and wide address windows and random back-pressure, so the bench sees both heavy merging and long split sequences.

// File: rtl/coal_pkg.sv
// Shared types and helpers for the request coalescer.
// Assumes segment sizes of 32, 64 and 128 bytes only.
package coal_pkg;
    typedef enum logic [1:0] {
        SEG_32  = 2'd0,
        SEG_64  = 2'd1,
        SEG_128 = 2'd2
    } seg_code_t;

    // Starting segment for an element width code
    function automatic seg_code_t base_seg(input logic [1:0] esize);
        case (esize)
            2'd0:    return SEG_32;
            2'd1:    return SEG_64;
            default: return SEG_128;
        endcase
    endfunction

    // log2 of the byte size for a segment code
    function automatic logic [2:0] seg_log(input seg_code_t code);
        return 3'd5 + {1'b0, code};
    endfunction
endpackage

// File: rtl/coal_leader_pick.sv
// Priority picker: returns the index of the lowest set bit of the
// pending vector. Assumes the caller checks any_o before using idx_o.
module coal_leader_pick #(
    parameter int NUM_LANES = 16,
    localparam int IDX_W = $clog2(NUM_LANES)
) (
    input  logic [NUM_LANES-1:0] pending_i,
    output logic [IDX_W-1:0]     idx_o,
    output logic                 any_o
);
    // Scan from the top so the lowest set bit wins
    always_comb begin
        idx_o = '0;
        any_o = |pending_i;
        for (int i = NUM_LANES - 1; i >= 0; i--) begin
            if (pending_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/coal_seg_match.sv
// Per-lane segment compare: flags the pending lanes that share the
// leader's segment, and reports whether any of them differs from the
// leader in address bit 6 or bit 5. Assumes ADDR_W is at least 8.
module coal_seg_match
    import coal_pkg::*;
#(
    parameter int NUM_LANES = 16,
    parameter int ADDR_W    = 32
) (
    input  logic [ADDR_W-1:0]    lane_addr_i [NUM_LANES],
    input  logic [NUM_LANES-1:0] pending_i,
    input  logic [ADDR_W-1:0]    lead_addr_i,
    input  seg_code_t            seg_i,
    output logic [NUM_LANES-1:0] match_o,
    output logic                 diff6_o,
    output logic                 diff5_o
);
    logic [ADDR_W-1:0]    hi_mask;
    logic [NUM_LANES-1:0] d6;
    logic [NUM_LANES-1:0] d5;

    // Upper-bit mask that selects the segment number
    always_comb hi_mask = {ADDR_W{1'b1}} << seg_log(seg_i);

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        // Lane joins when pending and in the leader's segment
        always_comb begin
            match_o[i] = pending_i[i] &&
                         (((lane_addr_i[i] ^ lead_addr_i) & hi_mask) == '0);
            d6[i] = match_o[i] && (lane_addr_i[i][6] != lead_addr_i[6]);
            d5[i] = match_o[i] && (lane_addr_i[i][5] != lead_addr_i[5]);
        end
    end

    // Reduce the per-lane half-difference flags
    always_comb begin
        diff6_o = |d6;
        diff5_o = |d5;
    end
endmodule

// File: rtl/coal_size_shrink.sv
// Segment reduction: halves 128 to 64 when all used bytes share bit 6,
// then halves 64 to 32 when they also share bit 5.
module coal_size_shrink
    import coal_pkg::*;
(
    input  seg_code_t base_i,
    input  logic      diff6_i,
    input  logic      diff5_i,
    output seg_code_t final_o
);
    // Cascade of the two halving steps
    always_comb begin
        final_o = base_i;
        if (final_o == SEG_128 && !diff6_i) final_o = SEG_64;
        if (final_o == SEG_64  && !diff5_i) final_o = SEG_32;
    end
endmodule

// File: rtl/coal_unit.sv
// Coalescer top: captures one lane-group request, then emits one aligned
// transaction per step until no lane is pending, then pulses done.
// Assumes lane addresses are aligned to the element size.
module coal_unit
    import coal_pkg::*;
#(
    parameter int NUM_LANES = 16,
    parameter int ADDR_W    = 32,
    localparam int IDX_W    = $clog2(NUM_LANES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [NUM_LANES*ADDR_W-1:0] req_addr,
    input  logic [NUM_LANES-1:0]        req_mask,
    input  logic [1:0]                  req_esize,
    output logic                        txn_valid,
    input  logic                        txn_ready,
    output logic [ADDR_W-1:0]           txn_addr,
    output logic [1:0]                  txn_size,
    output logic [NUM_LANES-1:0]        txn_mask,
    output logic                        done
);
    typedef enum logic {ST_IDLE, ST_BUSY} state_t;

    state_t               state_q;
    logic [ADDR_W-1:0]    lane_q [NUM_LANES];
    logic [NUM_LANES-1:0] pending_q;
    logic [1:0]           esize_q;

    logic [IDX_W-1:0]     lead_idx;
    logic                 lead_any;
    logic [ADDR_W-1:0]    lead_addr;
    seg_code_t            seg_base;
    seg_code_t            seg_final;
    logic [NUM_LANES-1:0] match;
    logic                 diff6;
    logic                 diff5;

    coal_leader_pick #(.NUM_LANES(NUM_LANES)) pick_i (
        .pending_i (pending_q),
        .idx_o     (lead_idx),
        .any_o     (lead_any)
    );

    // Leader address and starting segment
    always_comb begin
        lead_addr = lane_q[lead_idx];
        seg_base  = base_seg(esize_q);
    end

    coal_seg_match #(.NUM_LANES(NUM_LANES), .ADDR_W(ADDR_W)) match_i (
        .lane_addr_i (lane_q),
        .pending_i   (pending_q),
        .lead_addr_i (lead_addr),
        .seg_i       (seg_base),
        .match_o     (match),
        .diff6_o     (diff6),
        .diff5_o     (diff5)
    );

    coal_size_shrink shrink_i (
        .base_i  (seg_base),
        .diff6_i (diff6),
        .diff5_i (diff5),
        .final_o (seg_final)
    );

    // Output channel and status decode
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        txn_valid = (state_q == ST_BUSY) && lead_any;
        done      = (state_q == ST_BUSY) && !lead_any;
        txn_size  = seg_final;
        txn_mask  = match;
        txn_addr  = lead_addr & ({ADDR_W{1'b1}} << seg_log(seg_final));
    end

    // Request capture, pending-lane retirement and state sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pending_q <= '0;
            esize_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    state_q   <= ST_BUSY;
                    pending_q <= req_mask;
                    esize_q   <= req_esize;
                end
                ST_BUSY: begin
                    if (!lead_any)      state_q   <= ST_IDLE;
                    else if (txn_ready) pending_q <= pending_q & ~match;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Lane address capture, no reset needed for data
    always_ff @(posedge clk) begin
        if (state_q == ST_IDLE && req_valid) begin
            for (int i = 0; i < NUM_LANES; i++)
                lane_q[i] <= req_addr[i*ADDR_W +: ADDR_W];
        end
    end
endmodule

// File: rtl/coal_unit_chk.sv
// Protocol checker for coal_unit, bound to every instance of it.
module coal_unit_chk #(
    parameter int NUM_LANES = 16,
    parameter int ADDR_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_ready,
    input logic                 txn_valid,
    input logic                 txn_ready,
    input logic [ADDR_W-1:0]    txn_addr,
    input logic [1:0]           txn_size,
    input logic [NUM_LANES-1:0] txn_mask,
    input logic                 done
);
    logic [6:0] low_bits;

    // Bits that must be zero for the presented size
    always_comb begin
        case (txn_size)
            2'd0:    low_bits = 7'h1F;
            2'd1:    low_bits = 7'h3F;
            default: low_bits = 7'h7F;
        endcase
    end

    // R8
    txn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr) &&
        $stable(txn_mask) && $stable(txn_size));

    // R3
    txn_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> txn_mask != '0);

    // R5
    txn_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_addr[6:0] & low_bits) == 7'h0 && txn_size != 2'd3);

    // R9
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && txn_valid));

    // R9
    idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && txn_valid));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind coal_unit coal_unit_chk #(.NUM_LANES(NUM_LANES), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .txn_valid (txn_valid),
    .txn_ready (txn_ready),
    .txn_addr  (txn_addr),
    .txn_size  (txn_size),
    .txn_mask  (txn_mask),
    .done      (done)
);

// File: tb/coal_unit_tb_top.sv
// Bench for coal_unit: directed corner cases plus seeded random requests,
// compared with a model computed from the requirements.
module coal_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [N*AW-1:0] req_addr = '0;
    logic [N-1:0]  req_mask = '0;
    logic [1:0]    req_esize = '0;
    logic          txn_valid;
    logic          txn_ready = 1'b0;
    logic [AW-1:0] txn_addr;
    logic [1:0]    txn_size;
    logic [N-1:0]  txn_mask;
    logic          done;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0] lane_a [N];
    logic [AW-1:0] exp_addr [N];
    logic [1:0]    exp_size [N];
    logic [N-1:0]  exp_mask [N];
    int            exp_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    coal_unit #(.NUM_LANES(N), .ADDR_W(AW)) dut_i (
        .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_mask,
        .req_esize, .txn_valid, .txn_ready, .txn_addr, .txn_size,
        .txn_mask, .done
    );

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Model from R2..R6
    task automatic model(input logic [N-1:0] mask, input logic [1:0] esz);
        logic [N-1:0] pend = mask;
        exp_cnt = 0;
        while (pend != '0) begin
            int lead = 0;
            int lg;
            logic [N-1:0] m = '0;
            logic d6 = 1'b0;
            logic d5 = 1'b0;
            for (int i = N - 1; i >= 0; i--) if (pend[i]) lead = i;
            lg = (esz == 2'd0) ? 5 : (esz == 2'd1) ? 6 : 7;
            for (int i = 0; i < N; i++)
                if (pend[i] && ((lane_a[i] >> lg) == (lane_a[lead] >> lg))) begin
                    m[i] = 1'b1;
                    if (lane_a[i][6] != lane_a[lead][6]) d6 = 1'b1;
                    if (lane_a[i][5] != lane_a[lead][5]) d5 = 1'b1;
                end
            if (lg == 7 && !d6) lg = 6;
            if (lg == 6 && !d5) lg = 5;
            exp_addr[exp_cnt] = lane_a[lead] & ~((32'd1 << lg) - 32'd1);
            exp_size[exp_cnt] = 2'(lg - 5);
            exp_mask[exp_cnt] = m;
            exp_cnt++;
            pend &= ~m;
        end
    endtask

    // Send one request, collect and compare every transaction
    task automatic run_req(input logic [N-1:0] mask, input logic [1:0] esz, input string tag);
        int k = 0;
        logic prev_evt = 1'b1;
        logic seen_done = 1'b0;
        model(mask, esz);
        @(negedge clk);
        check({"R1 idle ready ", tag}, 64'(req_ready), 64'd1);
        for (int i = 0; i < N; i++) req_addr[i*AW +: AW] = lane_a[i];
        req_mask  = mask;
        req_esize = esz;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 0; cyc < 300 && !seen_done; cyc++) begin
            logic acc = 1'b0;
            if (done) begin
                seen_done = 1'b1;
                check({"R6 txn count ", tag}, 64'(k), 64'(exp_cnt));
                check({"R7 done timing ", tag}, 64'(prev_evt), 64'd1);
            end else begin
                txn_ready = ($urandom % 4) != 0;
                if (txn_valid && txn_ready) begin
                    acc = 1'b1;
                    if (k < exp_cnt) begin
                        check({"R3 txn_mask ", tag}, 64'(txn_mask), 64'(exp_mask[k]));
                        check({"R5 txn_addr ", tag}, 64'(txn_addr), 64'(exp_addr[k]));
                        check({"R4 txn_size ", tag}, 64'(txn_size), 64'(exp_size[k]));
                    end else begin
                        check({"R6 extra txn ", tag}, 64'(k), 64'(exp_cnt));
                    end
                    k++;
                end
                prev_evt = acc;
                @(negedge clk);
            end
        end
        txn_ready = 1'b0;
        if (!seen_done) check({"R7 done missing ", tag}, 64'd0, 64'd1);
    endtask

    task automatic fill_stride(input logic [AW-1:0] base, input int stride);
        for (int i = 0; i < N; i++) lane_a[i] = base + AW'(i * stride);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset ready", 64'(req_ready), 64'd1);
        check("R1 reset valid", 64'(txn_valid), 64'd0);
        check("R1 reset done", 64'(done), 64'd0);

        // R7 empty mask
        fill_stride(32'h100, 4);
        run_req(16'h0000, 2'd2, "empty");
        // R4 unit-stride words shrink to 64
        fill_stride(32'h1000, 4);
        run_req(16'hFFFF, 2'd2, "words_unit");
        fill_stride(32'h1040, 4);
        run_req(16'hFFFF, 2'd2, "words_upper");
        // R2 stride-8 words keep 128
        fill_stride(32'h2000, 8);
        run_req(16'hFFFF, 2'd2, "words_s8");
        // R2 bytes in one 32-byte segment
        fill_stride(32'h3010, 1);
        run_req(16'hFFFF, 2'd0, "bytes");
        // R2 halfwords spread over several 64-byte segments
        fill_stride(32'h4000, 16);
        run_req(16'hFFFF, 2'd1, "halves");
        // R3 broadcast with sparse mask
        fill_stride(32'h5000, 0);
        run_req(16'hA5A5, 2'd3, "bcast");
        // R3 reversed layout, leader by lane number
        for (int i = 0; i < N; i++) lane_a[i] = 32'h6000 + AW'((15 - i) * 16);
        run_req(16'hFFFF, 2'd2, "reversed");
        // R6 masked-off lanes carry garbage addresses
        fill_stride(32'h7000, 4);
        for (int i = 0; i < N; i++) if (i < 4 || i > 7) lane_a[i] = $urandom & 32'hFFFF_FFF8;
        run_req(16'h00F0, 2'd2, "inactive");
        // R3 single top lane
        run_req(16'h8000, 2'd3, "top_lane");

        // Random requests, narrow and wide windows
        for (int t = 0; t < 150; t++) begin
            logic [1:0] esz = 2'($urandom % 4);
            logic [AW-1:0] base = $urandom & 32'hFFFF_FE00;
            int win = (t % 2 == 0) ? 128 : 1024;
            logic [N-1:0] mask = (t % 5 == 0) ? 16'hFFFF : 16'($urandom);
            for (int i = 0; i < N; i++)
                lane_a[i] = (base + AW'($urandom % win)) & ~((32'd1 << esz) - 32'd1);
            run_req(mask, esz, "random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule